// File: doc/BRIEF.md
# Presettable Quadrature Position Counter

This block turns one pair of two-phase encoder signals into a signed-free 16-bit position count. Both phases first pass through a synchronizer. Every valid single-phase transition, rising or falling, moves the count by one. This is four counts per full encoder cycle. A direction-polarity pin selects which phase order counts up, and an enable pin freezes the count.

A host presets the count one byte at a time and reads either byte at any moment through a byte-select read port. Every step the counter accepts also produces a single-cycle event pulse, which an interrupt collector elsewhere can use. The host pins are plain register-style strobes. They have no handshake and no back-pressure: a write is taken in the cycle its strobe is high, and read data follows the select combinationally. The encoder edges are assumed to be far slower than the system clock.

Top module: `quad_pos_counter`

## Requirements
- R1: While `rst_n` is low the count is 0x0000 and `cnt_evt` is 0.
- R2: Each change of exactly one synchronized phase moves the count by exactly one. The count appears on the read port three rising clock edges after the input pin changes.
- R3: Phase order is taken as the sequence {a,b} = 00, 10, 11, 01, 00. With `dir_pol` = 1, a step forward in this sequence (A leading B) adds one and a step backward (B leading A) subtracts one.
- R4: With `dir_pol` = 0 the direction of R3 is reversed.
- R5: A transition in which both phases change in the same synchronized sample is discarded. It does not change the count and does not raise `cnt_evt`.
- R6: With `cnt_en` = 0 the count holds and no `cnt_evt` is raised. Phase edges seen while disabled are not applied after the block is enabled again.
- R7: The count wraps modulo 2^16: 0xFFFF plus one gives 0x0000, and 0x0000 minus one gives 0xFFFF.
- R8: A write with `wr_sel` = 0 replaces bits 7:0 and a write with `wr_sel` = 1 replaces bits 15:8. The other byte is left as it was.
- R9: When a write and an accepted step fall on the same clock edge, the write wins. The step is dropped and `cnt_evt` stays low.
- R10: `rd_data` shows bits 7:0 of the count when `rd_sel` = 0 and bits 15:8 when `rd_sel` = 1. It is valid at any time.
- R11: `cnt_evt` is high for exactly the one cycle in which an accepted step changes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| cnt_en | input | 1 | Counting enable |
| dir_pol | input | 1 | Direction polarity (1: A leading B counts up) |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 1 | Byte index for writes (0 low, 1 high) |
| wr_data | input | 8 | Byte write data |
| rd_sel | input | 1 | Byte index for reads (0 low, 1 high) |
| rd_data | output | 8 | Selected count byte |
| cnt_evt | output | 1 | One-cycle pulse per accepted step |

## Verification
A host byte write and a decoded encoder step can land on the same clock edge, and the block must resolve them in favour of the write. The bench provokes this by changing a phase and asserting the write strobe exactly two clock edges later. This is the edge on which the synchronized step reaches the counter. It then judges the outcome by reading back the written byte value unchanged by the step, and by checking that no event pulse was counted. The checker also holds that any cycle following a write shows no event and exactly the written byte.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  // Decoded step request handed from the phase decoder to the counter.
  typedef struct packed {
    logic vld;  // exactly one phase moved
    logic up;   // direction after polarity
  } qpc_step_t;

  // Position of a phase pair in the cycle 00 -> 10 -> 11 -> 01.
  function automatic logic [1:0] phase_pos(input logic [1:0] ab);
    return {ab[0], ab[1] ^ ab[0]};
  endfunction

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pol,
  input  logic [1:0] ab_now,
  output qpc_step_t step
);

  logic [1:0] ab_prev;
  logic [1:0] delta;
  logic       fwd;

  // The previous sample always tracks, so disabled periods leave no backlog.
  always_ff @(posedge clk) begin
    if (!rst_n) ab_prev <= 2'b00;
    else        ab_prev <= ab_now;
  end

  always_comb begin
    delta    = phase_pos(ab_now) - phase_pos(ab_prev);
    fwd      = (delta == 2'd1);
    step.vld = (delta == 2'd1) || (delta == 2'd3);
    step.up  = pol ? fwd : !fwd;
  end

endmodule

// File: rtl/qpc_count.sv
module qpc_count
  import qpc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NBYTES = CNT_W / BYTE_W,
  localparam int SELW   = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  qpc_step_t         step,
  input  logic              wr_en,
  input  logic [SELW-1:0]   wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              evt
);

  logic [CNT_W-1:0] count_nxt;
  logic             take_step;

  assign take_step = en && step.vld && !wr_en;

  always_comb begin
    count_nxt = count;
    if (wr_en) begin
      for (int i = 0; i < NBYTES; i++) begin
        if (wr_sel == SELW'(i)) count_nxt[i*BYTE_W +: BYTE_W] = wr_data;
      end
    end else if (take_step) begin
      count_nxt = step.up ? count + CNT_W'(1) : count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      evt   <= 1'b0;
    end else begin
      count <= count_nxt;
      evt   <= take_step;
    end
  end

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              cnt_en,
  input  logic              dir_pol,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  output logic              cnt_evt
);

  logic [1:0]       ab_sync;
  qpc_step_t        step;
  logic [CNT_W-1:0] count_q;

  qpc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in({enc_a, enc_b}), .sync_out(ab_sync)
  );

  qpc_decode u_dec (
    .clk(clk), .rst_n(rst_n), .pol(dir_pol), .ab_now(ab_sync), .step(step)
  );

  qpc_count #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .step(step),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count(count_q), .evt(cnt_evt)
  );

  assign rd_data = rd_sel ? count_q[2*BYTE_W-1:BYTE_W] : count_q[BYTE_W-1:0];

endmodule

// File: rtl/qpc_check.sv
module qpc_check #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [BYTE_W-1:0] wr_data,
  input logic [CNT_W-1:0]  count,
  input logic              evt
);

  // R2, R7: without a write the count moves by at most one, wrapping.
  p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && count != $past(count)) |->
      (count - $past(count) == CNT_W'(1) || $past(count) - count == CNT_W'(1)));

  // R6: disabled cycle leaves the count and the event quiet.
  p_hold_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(en) && !$past(wr_en)) |-> ($stable(count) && !evt));

  // R8: low-byte write.
  p_write_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !$past(wr_sel)) |->
      (count[BYTE_W-1:0] == $past(wr_data) && count[CNT_W-1:BYTE_W] == $past(count[CNT_W-1:BYTE_W])));

  // R8: high-byte write.
  p_write_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(wr_sel)) |->
      (count[CNT_W-1:BYTE_W] == $past(wr_data) && count[BYTE_W-1:0] == $past(count[BYTE_W-1:0])));

  // R9: a write cycle never yields an event.
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> !evt);

  // R11: an event always accompanies a change of count.
  p_evt_moves_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (count != $past(count)));

endmodule

bind quad_pos_counter qpc_check #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(cnt_en), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .count(count_q), .evt(cnt_evt)
);

// File: tb/quad_pos_counter_test.sv
module quad_pos_counter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_a = 1'b0, enc_b = 1'b0;
  logic       cnt_en = 1'b1, dir_pol = 1'b1;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       cnt_evt;

  int n_run = 0, n_fail = 0;
  int evt_total = 0;
  bit evt_wide = 1'b0;
  logic evt_d = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;  // 100 MHz

  quad_pos_counter uut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .cnt_en(cnt_en), .dir_pol(dir_pol), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .cnt_evt(cnt_evt)
  );

  always @(posedge clk) begin
    if (cnt_evt) evt_total++;
    if (cnt_evt && evt_d) evt_wide = 1'b1;
    evt_d <= cnt_evt;
  end

  // {a, b, expected count}, polarity 1, enabled, starting from 0x0000
  localparam logic [17:0] VEC [15] = '{
    {1'b1, 1'b0, 16'h0001}, {1'b1, 1'b1, 16'h0002}, {1'b0, 1'b1, 16'h0003},
    {1'b0, 1'b0, 16'h0004}, {1'b0, 1'b1, 16'h0003}, {1'b1, 1'b1, 16'h0002},
    {1'b1, 1'b0, 16'h0001}, {1'b0, 1'b0, 16'h0000}, {1'b0, 1'b0, 16'h0000},
    {1'b1, 1'b1, 16'h0000}, {1'b0, 1'b0, 16'h0000}, {1'b1, 1'b0, 16'h0001},
    {1'b0, 1'b0, 16'h0000}, {1'b0, 1'b1, 16'hFFFF}, {1'b0, 1'b0, 16'h0000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read16(output logic [15:0] v);
    rd_sel = 1'b0; #1 v[7:0] = rd_data;
    rd_sel = 1'b1; #1 v[15:8] = rd_data;
    rd_sel = 1'b0;
  endtask

  task automatic move(input logic a, input logic b);
    @(negedge clk); enc_a = a; enc_b = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic wbyte(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    logic [15:0] v, prev;
    int e0;
    repeat (3) @(negedge clk);
    read16(v); chk("R1 reset count", v, 16'h0000);
    chk("R1 reset event", {15'd0, cnt_evt}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R2, R3, R5, R7, R11
    prev = 16'h0000;
    for (int i = 0; i < 15; i++) begin
      e0 = evt_total;
      move(VEC[i][17], VEC[i][16]);
      read16(v);
      chk("R2/R3/R5/R7 table count", v, VEC[i][15:0]);
      chk("R11 event per step", 16'(evt_total - e0), (VEC[i][15:0] != prev) ? 16'd1 : 16'd0);
      prev = VEC[i][15:0];
    end

    // R4 reversed polarity
    dir_pol = 1'b0;
    move(1'b1, 1'b0); read16(v); chk("R4 reversed down", v, 16'hFFFF);
    move(1'b0, 1'b0); read16(v); chk("R4 reversed up", v, 16'h0000);

    // R6 disabled
    e0 = evt_total;
    cnt_en = 1'b0;
    move(1'b1, 1'b0); move(1'b1, 1'b1);
    read16(v); chk("R6 hold while disabled", v, 16'h0000);
    chk("R6 no event while disabled", 16'(evt_total - e0), 16'd0);
    cnt_en = 1'b1;
    repeat (4) @(negedge clk);
    read16(v); chk("R6 no backlog on enable", v, 16'h0000);
    move(1'b0, 1'b1); read16(v); chk("R6 counting resumes", v, 16'hFFFF);
    dir_pol = 1'b1;

    // R8 byte writes, R10 byte reads
    wbyte(1'b0, 8'h34); read16(v); chk("R8 low byte write", v, 16'hFF34);
    wbyte(1'b1, 8'h12); read16(v); chk("R8 high byte write", v, 16'h1234);
    rd_sel = 1'b0; #1 chk("R10 read low", {8'h00, rd_data}, 16'h0034);
    rd_sel = 1'b1; #1 chk("R10 read high", {8'h00, rd_data}, 16'h0012);
    rd_sel = 1'b0;

    // R9 write colliding with a step (01 -> 00 would count up)
    e0 = evt_total;
    @(negedge clk); enc_a = 1'b0; enc_b = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);
    read16(v); chk("R9 write wins over step", v, 16'h1200);
    chk("R9 no event on collision", 16'(evt_total - e0), 16'd0);

    // R7 wrap up from a preset 0xFFFF
    wbyte(1'b0, 8'hFF); wbyte(1'b1, 8'hFF);
    move(1'b1, 1'b0); read16(v); chk("R7 wrap up", v, 16'h0000);

    chk("R11 event one cycle wide", {15'd0, evt_wide}, 16'h0000);

    // R1 reset mid-run
    move(1'b1, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    read16(v); chk("R1 reset mid-run", v, 16'h0000);
    chk("R1 event low in reset", {15'd0, cnt_evt}, 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule